// File: doc/BRIEF.md
# Compact 7-Bit Biosignal Packet Encoder

This block turns one set of biosignal samples into a short framed byte packet for a slow serial link. A set holds six 10-bit channel samples and one 8-bit auxiliary value. It is offered with a one-cycle load strobe. The encoder captures the set and then emits eleven bytes on a ready/valid byte stream. Each byte carries seven payload bits. Bit 7 stays clear in every byte except the final one, so a receiver that lost its place can find the next packet boundary by looking for the single byte with its top bit set.

The first two bytes carry a 6-bit rolling packet number and the auxiliary value. The samples follow in pairs. For each pair the encoder sends the first channel's low seven bits, then the second channel's low seven bits, then one byte that holds both channels' upper three bits, kept apart by a zero spacer bit. While a packet is in flight, a further load strobe is refused and reported on a one-cycle overrun flag. A load on the same cycle that the final byte is taken starts the next packet with no idle cycle.

Top module: `eeg7_pkt_enc`

## Requirements
- R1: After reset `out_valid_o` and `overrun_o` are 0, `out_data_o` is 0, and the first packet carries packet number 0.
- R2: Byte 0 of a packet is {1'b0, packet number[5:0], aux[7]}.
- R3: Byte 1 of a packet is {1'b0, aux[6:0]}.
- R4: For pair k (channels 2k and 2k+1, k = 0..2), byte 2+3k is {1'b0, ch[2k][6:0]} and byte 3+3k is {1'b0, ch[2k+1][6:0]}. Channel c sits in `ch_i[10c+9:10c]`.
- R5: Byte 4+3k is {sync, ch[2k][9:7], 1'b0, ch[2k+1][9:7]}, so bit 3 of every high byte is 0.
- R6: Bit 7 of bytes 0 to 9 is 0, and bit 7 of byte 10 is 1.
- R7: A packet is exactly 11 handshakes long. After its last byte is taken with no new load, `out_valid_o` falls on the next cycle.
- R8: The packet number advances by one for each completed packet and wraps from 63 to 0.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `out_data_o` hold their values into the next cycle.
- R10: A load while a packet is in flight, other than on the cycle its last byte is taken, is refused. It raises `overrun_o` for one cycle, and the bytes of the current packet are unchanged.
- R11: A load while idle, or on the cycle the last byte is taken, is accepted with no overrun, and byte 0 of the new packet is valid on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Strobe offering a new sample set |
| ch_i | input | 60 | Six 10-bit samples, channel c at bits 10c+9:10c |
| aux_i | input | 8 | Auxiliary value |
| out_ready_i | input | 1 | Downstream accepts the current byte |
| out_data_o | output | 8 | Current packet byte, 0 when idle |
| out_valid_o | output | 1 | Byte on `out_data_o` is valid |
| overrun_o | output | 1 | One-cycle pulse after a refused load |

## Verification
The bench builds the encoder with its default format: six channels of ten bits split seven and three, an 8-bit auxiliary value and a 6-bit packet number. Because the number has only 64 states, a run of seventy packets wraps it completely, and every byte of every packet is checked against values worked out arithmetically. The sample sets include all-zero, all-ones and alternating patterns, and the ready pattern stalls at shifting byte positions. Refused loads at a mid-packet byte and at a stalled final byte, and two chained back-to-back packets, reach the overrun and handoff corner cases.

// File: rtl/eeg7_pkg.sv
package eeg7_pkg;
  localparam int unsigned SMP_W   = 10;
  localparam int unsigned LOW_W   = 7;
  localparam int unsigned NCH     = 6;
  localparam int unsigned AUX_W   = 8;
  localparam int unsigned CNT_W   = 6;
  localparam int unsigned BYTE_W  = 8;

  function automatic int unsigned pkt_bytes(input int unsigned nch);
    return 2 + 3 * (nch / 2);
  endfunction
endpackage

// File: rtl/eeg7_rst_sync.sv
module eeg7_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/eeg7_capture.sv
module eeg7_capture #(
  parameter int unsigned NCH   = eeg7_pkg::NCH,
  parameter int unsigned SMP_W = eeg7_pkg::SMP_W,
  parameter int unsigned AUX_W = eeg7_pkg::AUX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_en,
  input  logic [NCH*SMP_W-1:0] ch_i,
  input  logic [AUX_W-1:0]     aux_i,
  output logic [NCH*SMP_W-1:0] ch_q,
  output logic [AUX_W-1:0]     aux_q
);
  logic [NCH*SMP_W-1:0] ch_d;
  logic [AUX_W-1:0]     aux_d;

  always_comb begin
    ch_d  = ch_q;
    aux_d = aux_q;
    if (cap_en) begin
      ch_d  = ch_i;
      aux_d = aux_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q  <= '0;
      aux_q <= '0;
    end else begin
      ch_q  <= ch_d;
      aux_q <= aux_d;
    end
  end
endmodule

// File: rtl/eeg7_seq.sv
module eeg7_seq #(
  parameter int unsigned PKT_BYTES = 11,
  parameter int unsigned CNT_W     = eeg7_pkg::CNT_W,
  localparam int unsigned IDX_W    = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             out_ready_i,
  output logic             cap_en,
  output logic             valid_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             overrun_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);

  logic             fire;
  logic             last_fire;
  logic             free;
  logic             valid_d;
  logic [IDX_W-1:0] idx_d;
  logic [CNT_W-1:0] cnt_d;
  logic             overrun_d;

  always_comb begin
    fire      = valid_q && out_ready_i;
    last_fire = fire && (idx_q == LAST_IDX);
    free      = !valid_q || last_fire;
    cap_en    = load_i && free;
    overrun_d = load_i && !free;

    valid_d = valid_q;
    if (cap_en)         valid_d = 1'b1;
    else if (last_fire) valid_d = 1'b0;

    idx_d = idx_q;
    if (cap_en || last_fire) idx_d = '0;
    else if (fire)           idx_d = idx_q + 1'b1;

    cnt_d = cnt_q;
    if (last_fire) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      idx_q     <= '0;
      cnt_q     <= '0;
      overrun_q <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      idx_q     <= idx_d;
      cnt_q     <= cnt_d;
      overrun_q <= overrun_d;
    end
  end
endmodule

// File: rtl/eeg7_fmt.sv
module eeg7_fmt #(
  parameter int unsigned NCH    = eeg7_pkg::NCH,
  parameter int unsigned SMP_W  = eeg7_pkg::SMP_W,
  parameter int unsigned LOW_W  = eeg7_pkg::LOW_W,
  parameter int unsigned AUX_W  = eeg7_pkg::AUX_W,
  parameter int unsigned CNT_W  = eeg7_pkg::CNT_W,
  parameter int unsigned BYTE_W = eeg7_pkg::BYTE_W,
  localparam int unsigned NPAIR     = NCH / 2,
  localparam int unsigned PKT_BYTES = 2 + 3 * NPAIR,
  localparam int unsigned IDX_W     = $clog2(PKT_BYTES)
) (
  input  logic [NCH*SMP_W-1:0] ch_i,
  input  logic [AUX_W-1:0]     aux_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 valid_i,
  output logic [BYTE_W-1:0]    byte_o
);
  logic [BYTE_W-1:0] slot [PKT_BYTES];

  assign slot[0] = {1'b0, cnt_i, aux_i[AUX_W-1]};
  assign slot[1] = {1'b0, aux_i[AUX_W-2:0]};

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [SMP_W-1:0] first_s;
    logic [SMP_W-1:0] second_s;
    logic             sync_b;
    assign first_s  = ch_i[(2*p)*SMP_W +: SMP_W];
    assign second_s = ch_i[(2*p+1)*SMP_W +: SMP_W];
    assign sync_b   = (p == NPAIR - 1) ? 1'b1 : 1'b0;
    assign slot[2+3*p] = {1'b0, first_s[LOW_W-1:0]};
    assign slot[3+3*p] = {1'b0, second_s[LOW_W-1:0]};
    assign slot[4+3*p] = {sync_b, first_s[SMP_W-1:LOW_W], 1'b0,
                          second_s[SMP_W-1:LOW_W]};
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < PKT_BYTES; i++) begin
      if (valid_i && (idx_i == IDX_W'(i))) byte_o = slot[i];
    end
  end
endmodule

// File: rtl/eeg7_pkt_enc.sv
module eeg7_pkt_enc #(
  parameter int unsigned NCH    = eeg7_pkg::NCH,
  parameter int unsigned SMP_W  = eeg7_pkg::SMP_W,
  parameter int unsigned LOW_W  = eeg7_pkg::LOW_W,
  parameter int unsigned AUX_W  = eeg7_pkg::AUX_W,
  parameter int unsigned CNT_W  = eeg7_pkg::CNT_W,
  parameter int unsigned BYTE_W = eeg7_pkg::BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [NCH*SMP_W-1:0] ch_i,
  input  logic [AUX_W-1:0]     aux_i,
  input  logic                 out_ready_i,
  output logic [BYTE_W-1:0]    out_data_o,
  output logic                 out_valid_o,
  output logic                 overrun_o
);
  localparam int unsigned PKT_BYTES = eeg7_pkg::pkt_bytes(NCH);
  localparam int unsigned IDX_W     = $clog2(PKT_BYTES);

  logic                 rst_n_s;
  logic                 cap_en;
  logic                 valid_q;
  logic [IDX_W-1:0]     idx_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [NCH*SMP_W-1:0] ch_q;
  logic [AUX_W-1:0]     aux_q;

  eeg7_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  eeg7_seq #(.PKT_BYTES(PKT_BYTES), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .load_i      (load_i),
    .out_ready_i (out_ready_i),
    .cap_en      (cap_en),
    .valid_q     (valid_q),
    .idx_q       (idx_q),
    .cnt_q       (cnt_q),
    .overrun_q   (overrun_o)
  );

  eeg7_capture #(.NCH(NCH), .SMP_W(SMP_W), .AUX_W(AUX_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .cap_en (cap_en),
    .ch_i   (ch_i),
    .aux_i  (aux_i),
    .ch_q   (ch_q),
    .aux_q  (aux_q)
  );

  eeg7_fmt #(
    .NCH(NCH), .SMP_W(SMP_W), .LOW_W(LOW_W), .AUX_W(AUX_W),
    .CNT_W(CNT_W), .BYTE_W(BYTE_W)
  ) u_fmt (
    .ch_i    (ch_q),
    .aux_i   (aux_q),
    .cnt_i   (cnt_q),
    .idx_i   (idx_q),
    .valid_i (valid_q),
    .byte_o  (out_data_o)
  );

  assign out_valid_o = valid_q;
endmodule

// File: rtl/eeg7_pkt_enc_chk.sv
module eeg7_pkt_enc_chk #(
  parameter int unsigned PKT_BYTES = 11,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned IDX_W    = $clog2(PKT_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              out_ready_i,
  input logic [BYTE_W-1:0] out_data_o,
  input logic              out_valid_o,
  input logic              overrun_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);

  logic [IDX_W-1:0] cidx;
  logic [CNT_W-1:0] prev_num;
  logic             seen;
  logic             at_last;
  logic             hi_slot;

  always_comb begin
    at_last = (cidx == LAST_IDX);
    hi_slot = (int'(cidx) >= 2) && (((int'(cidx) - 2) % 3) == 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cidx     <= '0;
      prev_num <= '0;
      seen     <= 1'b0;
    end else if (out_valid_o && out_ready_i) begin
      cidx <= at_last ? '0 : cidx + 1'b1;
      if (cidx == '0) begin
        prev_num <= out_data_o[CNT_W:1];
        seen     <= 1'b1;
      end
    end
  end

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_sync_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_data_o[BYTE_W-1] == at_last));

  p_spacer_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && hi_slot) |-> !out_data_o[3]);

  p_overrun_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && out_valid_o && !(out_ready_i && at_last)) |=> overrun_o);

  p_pkt_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && at_last && !load_i) |=> !out_valid_o);

  p_num_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && cidx == '0 && seen)
      |-> (out_data_o[CNT_W:1] == CNT_W'(prev_num + 1'b1)));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (!out_valid_o || (out_ready_i && at_last)))
      |=> (out_valid_o && !overrun_o));
endmodule

bind eeg7_pkt_enc eeg7_pkt_enc_chk #(
  .PKT_BYTES(eeg7_pkg::pkt_bytes(NCH)),
  .CNT_W(CNT_W),
  .BYTE_W(BYTE_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .overrun_o   (overrun_o)
);

// File: tb/eeg7_pkt_enc_tb.sv
module eeg7_pkt_enc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int NBYTES = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [59:0] ch_i = '0;
  logic [7:0]  aux_i = '0;
  logic        out_ready_i = 1'b0;
  logic [7:0]  out_data_o;
  logic        out_valid_o;
  logic        overrun_o;

  int total = 0;
  int bad = 0;
  int pkt_num = 0;
  int cyc = 0;
  int cur_ch [NCH];
  int cur_aux;
  int nxt_ch [NCH];
  int nxt_aux;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeg7_pkt_enc dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .ch_i(ch_i), .aux_i(aux_i),
    .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .out_valid_o(out_valid_o), .overrun_o(overrun_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_byte(input int i);
    int p, k, num;
    num = pkt_num % 64;
    if (i == 0) return (num << 1) | (cur_aux >> 7);
    if (i == 1) return cur_aux % 128;
    p = (i - 2) / 3;
    k = (i - 2) % 3;
    if (k == 0) return cur_ch[2*p] % 128;
    if (k == 1) return cur_ch[2*p+1] % 128;
    return ((cur_ch[2*p] >> 7) << 4) | (cur_ch[2*p+1] >> 7) | ((i == NBYTES-1) ? 128 : 0);
  endfunction

  function automatic string tag_of(input int i);
    if (i == 0) return "R2";
    if (i == 1) return "R3";
    if (((i - 2) % 3) == 2) return "R5";
    return "R4";
  endfunction

  task automatic make_set(input int p);
    for (int c = 0; c < NCH; c++) begin
      if (p == 1)      nxt_ch[c] = 0;
      else if (p == 2) nxt_ch[c] = 1023;
      else if (p == 3) nxt_ch[c] = (c % 2 == 0) ? 'h2AA : 'h155;
      else             nxt_ch[c] = (p * 37 + c * 151 + p * c * 13) % 1024;
    end
    if (p == 1)      nxt_aux = 0;
    else if (p == 2) nxt_aux = 255;
    else             nxt_aux = (p * 29 + 3) % 256;
  endtask

  task automatic drive_set(input bit use_next, input bit garble);
    for (int c = 0; c < NCH; c++) begin
      ch_i[c*10 +: 10] = 10'(use_next ? nxt_ch[c] : cur_ch[c]);
      if (garble) ch_i[c*10 +: 10] = ~ch_i[c*10 +: 10];
    end
    aux_i = 8'(use_next ? nxt_aux : cur_aux);
    if (garble) aux_i = ~aux_i;
  endtask

  // inj_at: byte index at which a refused load is offered (-1 = none)
  task automatic run_packet(input int inj_at, input bit chain, input bit preloaded);
    int idx;
    bit inj_pend;
    bit first;
    bit stalled;
    int prev_data;
    int bad_before;
    idx = 0;
    inj_pend = 0;
    stalled = 0;
    prev_data = 0;
    first = preloaded;
    bad_before = bad;
    if (!preloaded) begin
      @(negedge clk);
      drive_set(1'b0, 1'b0);
      load_i = 1'b1;
    end
    while (idx < NBYTES) begin
      bit rdy;
      if (!first) @(negedge clk);
      first = 0;
      load_i = 1'b0;
      if (inj_pend) begin
        check(overrun_o == 1'b1, "R10 overrun raised", int'(overrun_o), 1);
        inj_pend = 0;
      end
      if (!out_valid_o) begin
        check(1'b0, "R7 packet ended early", idx, NBYTES);
        break;
      end
      check(int'(out_data_o) == exp_byte(idx), tag_of(idx), int'(out_data_o), exp_byte(idx));
      check(out_data_o[7] == (idx == NBYTES-1), "R6 sync bit", int'(out_data_o[7]),
            int'(idx == NBYTES-1));
      if (idx == 0)
        check(int'(out_data_o[6:1]) == pkt_num % 64, "R8 packet number",
              int'(out_data_o[6:1]), pkt_num % 64);
      if (stalled)
        check(int'(out_data_o) == prev_data, "R9 held byte", int'(out_data_o), prev_data);
      rdy = (cyc % 3) != 1;
      if (idx == inj_at) begin
        rdy = 1'b0;
        drive_set(1'b0, 1'b1);
        load_i = 1'b1;
        inj_pend = 1;
        inj_at = -1;
      end
      if (chain && idx == NBYTES-1) begin
        rdy = 1'b1;
        drive_set(1'b1, 1'b0);
        load_i = 1'b1;
      end
      out_ready_i = rdy;
      stalled = !rdy;
      prev_data = int'(out_data_o);
      if (rdy) idx++;
      cyc++;
    end
    @(negedge clk);
    load_i = 1'b0;
    out_ready_i = 1'b0;
    pkt_num++;
    if (chain) begin
      check(out_valid_o == 1'b1, "R11 chained start", int'(out_valid_o), 1);
      check(overrun_o == 1'b0, "R11 no overrun", int'(overrun_o), 0);
    end else begin
      check(out_valid_o == 1'b0, "R7 valid falls", int'(out_valid_o), 0);
      check(overrun_o == 1'b0, "R11 no overrun on idle load", int'(overrun_o), 0);
    end
    if (inj_at == -1 && bad_before >= 0)
      check(bad == bad_before, "R10 packet unaltered", bad - bad_before, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    bit pre;
    pre = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid_o == 1'b0, "R1 valid after reset", int'(out_valid_o), 0);
    check(overrun_o == 1'b0, "R1 overrun after reset", int'(overrun_o), 0);
    check(out_data_o == 8'h00, "R1 data after reset", int'(out_data_o), 0);
    for (int p = 0; p < 70; p++) begin
      bit ch_flag;
      int inj;
      ch_flag = (p == 30) || (p == 50);
      inj = (p == 5) ? 3 : (p == 20) ? 7 : (p == 40) ? 10 : -1;
      if (!pre) begin
        make_set(p);
        cur_ch = nxt_ch;
        cur_aux = nxt_aux;
      end
      if (ch_flag) make_set(p + 1);
      run_packet(inj, ch_flag, pre);
      if (ch_flag) begin
        cur_ch = nxt_ch;
        cur_aux = nxt_aux;
      end
      pre = ch_flag;
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule